// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit biased exponent, 23-bit fraction) and returns a 32-bit product. The operands are captured on a one-cycle `start` strobe. The product and its exception flags are registered on the clock edge that samples `start`. A one-cycle `done` pulse follows on the next cycle. The datapath is combinational between the operand pins and a single output register.

The product's sign is the exclusive-OR of the operand signs. Its exponent is the sum of the biased operand exponents, with the bias taken away once. Its significand is the 48-bit product of the two 24-bit significands, each with the hidden bit restored. That significand product always lies in [1, 4), so a single optional right shift normalizes it. The result is then rounded to nearest, with ties going to even. A rounding carry-out renormalizes the result.

Subnormal inputs are read as zeros of the same sign. Infinities and NaNs follow the usual special-case rules. Results that leave the normal exponent range saturate to a signed infinity or to a signed zero, and a flag is raised.

Top module: `fpm_mult`

## Requirements
- R1: `done` is high in exactly the cycle after a cycle with `start` high, and low otherwise. `result` and the three flags change only on a clock edge where `start` is high; they hold between strobes.
- R2: For normal operands whose product stays in range, the result sign is the XOR of the input signs and the biased exponent is ea + eb − 127. The result is the correctly rounded product, for example 1.5 × 2.0 = 0x40400000.
- R3: When the significand product lies in [2, 4), it is shifted right by one and the exponent goes up by one. For example, −1.5 × 1.5 = 0xC0100000.
- R4: Rounding is to nearest, with ties to even. A tie with an odd kept LSB rounds up, and a tie with an even LSB is truncated. A rounding carry out of the significand yields fraction 0 and exponent + 1.
- R5: An operand with biased exponent 0 and a non-zero fraction acts as a zero of its own sign. No flag is raised for it.
- R6: Zero times infinity, in either order and with any signs, gives the quiet NaN 0x7FC00000 and raises `invalid`.
- R7: If either operand is a NaN (exponent 255, fraction non-zero), the result is 0x7FC00000 and `invalid` stays low.
- R8: Infinity times a non-zero finite value or an infinity gives an infinity whose sign is the XOR of the input signs. No flag is raised.
- R9: Zero times a finite value gives a zero whose sign is the XOR of the input signs. No flag is raised.
- R10: If the final biased exponent (after normalization and rounding) is 255 or more, the result is the signed infinity and `overflow` is raised.
- R11: If the final biased exponent is 0 or less, the result is the signed zero and `underflow` is raised. A final exponent of 1 is returned as a normal number.
- R12: While `rst` is high, `result` is 0 and `done`, `invalid`, `overflow` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe; the operands are sampled on this edge |
| op_a | input | 32 | First operand, single-precision format |
| op_b | input | 32 | Second operand, single-precision format |
| result | output | 32 | Registered product |
| done | output | 1 | High for one cycle after each strobe |
| invalid | output | 1 | The product was zero times infinity |
| overflow | output | 1 | The product was too large and saturated to infinity |
| underflow | output | 1 | The product was too small and flushed to zero |

## Verification
The block has only one register stage, so any error in classification, normalization or rounding shows up in `result` in the cycle right after the strobe. The bench checks each product at that point. A wrong normalization choice shows up as an exponent one step off and a fraction that is shifted. A wrong guard or sticky choice changes the LSB only on the tie and carry vectors. A wrong special-case ordering turns the NaN, infinity and zero cases into the wrong code or sets the wrong flag. Corrupted capture logic either changes `result` between strobes or misplaces `done`, and the idle-cycle checks catch this.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXPS_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NORM = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_cls_e;

    typedef struct packed {
        fp_cls_e             cls;
        logic                sign;
        logic [EXP_W-1:0]    exp;
        logic [SIG_W-1:0]    sig;
    } fp_opnd_t;

    typedef struct packed {
        logic [WORD_W-1:0]   word;
        logic                inv;
        logic                ovf;
        logic                unf;
    } fp_res_t;

    function automatic logic [WORD_W-1:0] make_inf(input logic s);
        return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] make_zero(input logic s);
        return {s, {(WORD_W-1){1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] make_qnan();
        return {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    endfunction

endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_opnd_t          opnd
);
    logic [EXP_W-1:0]  e;
    logic [FRAC_W-1:0] f;

    assign e = word[WORD_W-2 -: EXP_W];
    assign f = word[FRAC_W-1:0];

    always_comb begin
        opnd.sign = word[WORD_W-1];
        opnd.exp  = e;
        opnd.sig  = {1'b1, f};
        if (e == '0) begin
            // subnormals are flushed: treated as zero of the same sign
            opnd.cls = CLS_ZERO;
            opnd.sig = '0;
        end else if (e == EXP_W'(EXP_MAX)) begin
            opnd.cls = (f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            opnd.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  logic [PROD_W-1:0]        prod,
    input  logic signed [EXPS_W-1:0] exp_in,
    output logic [FRAC_W-1:0]        frac_out,
    output logic signed [EXPS_W-1:0] exp_out
);
    logic              hi;
    logic [FRAC_W-1:0] kept;
    logic              guard;
    logic              sticky;
    logic              up;
    logic [FRAC_W:0]   sum;

    assign hi = prod[PROD_W-1];

    // product in [2,4): one right shift; otherwise already normalized
    always_comb begin
        if (hi) begin
            kept   = prod[PROD_W-2 -: FRAC_W];
            guard  = prod[PROD_W-2-FRAC_W];
            sticky = |prod[PROD_W-3-FRAC_W:0];
        end else begin
            kept   = prod[PROD_W-3 -: FRAC_W];
            guard  = prod[PROD_W-3-FRAC_W];
            sticky = |prod[PROD_W-4-FRAC_W:0];
        end
    end

    assign up       = guard & (sticky | kept[0]);
    assign sum      = {1'b0, kept} + {{FRAC_W{1'b0}}, up};
    assign frac_out = sum[FRAC_W-1:0];
    assign exp_out  = exp_in + EXPS_W'(hi) + EXPS_W'(sum[FRAC_W]);
endmodule

// File: rtl/fpm_combine.sv
module fpm_combine
    import fpm_pkg::*;
(
    input  fp_opnd_t                 a,
    input  fp_opnd_t                 b,
    input  logic [FRAC_W-1:0]        frac,
    input  logic signed [EXPS_W-1:0] exp_fin,
    output fp_res_t                  res
);
    localparam logic signed [EXPS_W-1:0] EXP_TOP = EXPS_W'(EXP_MAX);
    localparam logic signed [EXPS_W-1:0] EXP_ONE = EXPS_W'(1);

    logic sgn;
    logic any_nan, any_inf, any_zero;

    assign sgn      = a.sign ^ b.sign;
    assign any_nan  = (a.cls == CLS_NAN)  || (b.cls == CLS_NAN);
    assign any_inf  = (a.cls == CLS_INF)  || (b.cls == CLS_INF);
    assign any_zero = (a.cls == CLS_ZERO) || (b.cls == CLS_ZERO);

    always_comb begin
        res = '0;
        if (any_nan) begin
            res.word = make_qnan();
        end else if (any_inf && any_zero) begin
            res.word = make_qnan();
            res.inv  = 1'b1;
        end else if (any_inf) begin
            res.word = make_inf(sgn);
        end else if (any_zero) begin
            res.word = make_zero(sgn);
        end else if (exp_fin >= EXP_TOP) begin
            res.word = make_inf(sgn);
            res.ovf  = 1'b1;
        end else if (exp_fin < EXP_ONE) begin
            res.word = make_zero(sgn);
            res.unf  = 1'b1;
        end else begin
            res.word = {sgn, exp_fin[EXP_W-1:0], frac};
        end
    end
endmodule

// File: rtl/fpm_mult.sv
module fpm_mult
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] result,
    output logic              done,
    output logic              invalid,
    output logic              overflow,
    output logic              underflow
);
    localparam int NUM_OPS = 2;

    logic [WORD_W-1:0]        words [NUM_OPS];
    fp_opnd_t                 opnd  [NUM_OPS];
    logic [PROD_W-1:0]        prod;
    logic signed [EXPS_W-1:0] exp_sum;
    logic signed [EXPS_W-1:0] exp_fin;
    logic [FRAC_W-1:0]        frac;
    fp_res_t                  res_d;
    fp_res_t                  res_q;
    logic                     done_q;

    assign words[0] = op_a;
    assign words[1] = op_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
        fpm_classify u_cls (.word(words[i]), .opnd(opnd[i]));
    end

    assign prod    = PROD_W'(opnd[0].sig) * PROD_W'(opnd[1].sig);
    assign exp_sum = signed'({2'b00, opnd[0].exp}) + signed'({2'b00, opnd[1].exp})
                   - EXPS_W'(BIAS);

    fpm_round u_rnd (
        .prod     (prod),
        .exp_in   (exp_sum),
        .frac_out (frac),
        .exp_out  (exp_fin)
    );

    fpm_combine u_cmb (
        .a       (opnd[0]),
        .b       (opnd[1]),
        .frac    (frac),
        .exp_fin (exp_fin),
        .res     (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= start;
            if (start) res_q <= res_d;
        end
    end

    assign result    = res_q.word;
    assign invalid   = res_q.inv;
    assign overflow  = res_q.ovf;
    assign underflow = res_q.unf;
    assign done      = done_q;

    // R1
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && $stable(result) && $stable({invalid, overflow, underflow})));

    // R6 R10 R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({invalid, overflow, underflow}));

    // R10
    ovf_inf_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R11
    unf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (result[WORD_W-2:0] == '0));

    // R6
    inv_nan_chk: assert property (@(posedge clk) disable iff (rst)
        invalid |-> (result == make_qnan()));
endmodule

// File: tb/sim_fpm_mult.sv
module sim_fpm_mult;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] result;
    logic        done, invalid, overflow, underflow;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    fpm_mult u0 (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .result(result), .done(done), .invalid(invalid),
        .overflow(overflow), .underflow(underflow)
    );

    typedef struct {
        logic [31:0] word;
        logic [2:0]  flg;   // {invalid, overflow, underflow}
    } exp_t;

    exp_t  sb_q[$];
    string tag_q[$];

    task automatic chk(input logic ok, input string req,
                       input logic [34:0] act, input logic [34:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] w, input logic [2:0] f, input string req);
        exp_t e;
        @(negedge clk);
        op_a  = a;
        op_b  = b;
        start = 1'b1;
        e.word = w;
        e.flg  = f;
        sb_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        start = 1'b0;
    endtask

    // monitor: compares every completed product against the scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R1 unexpected done", {result, invalid, overflow, underflow}, '0);
            end else begin
                exp_t  e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                chk({result, invalid, overflow, underflow} == {e.word, e.flg}, t,
                    {result, invalid, overflow, underflow}, {e.word, e.flg});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk({result, done, invalid, overflow, underflow} == '0, "R12",
            {result, invalid, overflow, underflow}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 plain products
        issue(32'h3FC00000, 32'h40000000, 32'h40400000, 3'b000, "R2 1.5x2");
        issue(32'h3F800000, 32'h3F800000, 32'h3F800000, 3'b000, "R2 1x1");
        // R3 product in [2,4)
        issue(32'hBFC00000, 32'h3FC00000, 32'hC0100000, 3'b000, "R3 -1.5x1.5");
        issue(32'h7F000000, 32'h3FFFFFFF, 32'h7F7FFFFF, 3'b000, "R2 max finite");
        // R4 rounding
        issue(32'h3F800001, 32'h3FC00000, 32'h3FC00002, 3'b000, "R4 tie odd up");
        issue(32'h3F800003, 32'h3FC00000, 32'h3FC00004, 3'b000, "R4 tie even down");
        issue(32'h3FDA1700, 32'h3F964000, 32'h40000000, 3'b000, "R4 carry renorm");
        // R5 subnormal flush
        issue(32'h00000001, 32'h40000000, 32'h00000000, 3'b000, "R5 pos subnormal");
        issue(32'h80400000, 32'h40000000, 32'h80000000, 3'b000, "R5 neg subnormal");
        // R6 zero times infinity
        issue(32'h00000000, 32'h7F800000, 32'h7FC00000, 3'b100, "R6 0xinf");
        issue(32'hFF800000, 32'h80000000, 32'h7FC00000, 3'b100, "R6 -infx-0");
        issue(32'h00000001, 32'h7F800000, 32'h7FC00000, 3'b100, "R6 subnormal x inf");
        // R7 NaN propagation
        issue(32'h7FC00001, 32'h3F800000, 32'h7FC00000, 3'b000, "R7 nan x 1");
        issue(32'h00000000, 32'hFF800001, 32'h7FC00000, 3'b000, "R7 0 x nan");
        issue(32'h7FFFFFFF, 32'h7F800000, 32'h7FC00000, 3'b000, "R7 nan x inf");
        // R8 infinities
        issue(32'h7F800000, 32'hC0000000, 32'hFF800000, 3'b000, "R8 inf x -2");
        issue(32'hFF800000, 32'hFF800000, 32'h7F800000, 3'b000, "R8 -inf x -inf");
        // R9 zeros
        issue(32'h00000000, 32'hC0400000, 32'h80000000, 3'b000, "R9 0 x -3");
        // R10 overflow
        issue(32'h7F000000, 32'h40000000, 32'h7F800000, 3'b010, "R10 pos overflow");
        issue(32'hFF000000, 32'h7F000000, 32'hFF800000, 3'b010, "R10 neg overflow");
        // R11 underflow
        issue(32'h00800000, 32'h3F000000, 32'h00000000, 3'b001, "R11 pos underflow");
        issue(32'h80800000, 32'h00800000, 32'h80000000, 3'b001, "R11 neg underflow");
        issue(32'h00800000, 32'h3F800000, 32'h00800000, 3'b000, "R11 exp 1 normal");

        // R1 idle cycles: new operands without strobe must not disturb outputs
        @(negedge clk);
        op_a = 32'h40000000;
        op_b = 32'h40000000;
        repeat (3) begin
            @(negedge clk);
            chk(!done && result == 32'h00800000 && {invalid, overflow, underflow} == 3'b000,
                "R1 hold", {result, invalid, overflow, underflow}, {32'h00800000, 3'b000});
        end
        // R1 a single later strobe produces exactly one done
        issue(32'h40000000, 32'h40000000, 32'h40800000, 3'b000, "R1 late strobe");
        @(negedge clk);
        chk(!done, "R1 done single", {34'b0, done}, '0);
        chk(sb_q.size() == 0, "R1 all results seen", 35'(sb_q.size()), '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule